// File: doc/BRIEF.md
# Byte-Port CRC16 Accumulator

This block keeps a 16-bit CRC result and exposes it through a byte-wide register bus. Two addresses are decoded. The control register carries three live bits: an initialization strobe, a preset select and a one-bit half pointer. The data port reads or overwrites one byte of the result. The pointer chooses the low or high byte of the result, and every data-port access toggles it. Software can therefore read or load the whole result with two back-to-back accesses.

Message bytes come in on a separate valid/ready stream. Each accepted byte advances the result by one CCITT step (polynomial 0x1021, most significant bit first, no reflection, no final XOR) in a single clock. The stream is normally always ready. It applies back-pressure, by holding `in_ready` low, only in a cycle where the register bus either writes the control register with the strobe set or writes the data port. In such a cycle the byte stays pending at the source and is taken on a later cycle. Register-bus reads respond combinationally in the same cycle as `rd_en`.

Top module: `crc16_byteport`

## Requirements
- R1: After the synchronous reset (`rst` high at a clock edge) the result is 0x0000, the pointer is 0 and the preset select is 0, so the control register reads 0x00.
- R2: A write to the control address (0x84) with bit 3 set loads all 16 result bits at the next edge. The value is 0xFFFF when bit 2 of the same write is 1 and 0x0000 when it is 0.
- R3: A control write stores bit 2 as the preset select and bit 0 as the pointer. A control read returns the preset select in bit 2 and the pointer in bit 0. Bit 3 is a strobe and always reads 0.
- R4: Control bits 7:4 and bit 1 always read 0, whatever was written to them.
- R5: A data-port (0x85) access reaches result bits 7:0 when the pointer is 0 and bits 15:8 when it is 1.
- R6: Every data-port read and every data-port write toggles the pointer. Control reads and accesses to other addresses leave it unchanged.
- R7: A data-port write replaces only the result byte that the pointer selects. The other byte is unchanged.
- R8: A stream byte taken while `in_valid` and `in_ready` are both high updates the result by one CCITT-0x1021 MSB-first step at that edge.
- R9: `in_ready` is low in any cycle with an initializing control write or with a data-port write, so the initialization or the byte load wins and the stream byte is not consumed. `in_ready` is high in every other cycle.
- R10: With no bus write and no accepted stream byte, the result holds its value.
- R11: Reads of any address other than the control and data addresses return 0x00 and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register-bus write strobe |
| rd_en | input | 1 | Register-bus read strobe |
| addr | input | 8 | Register-bus byte address |
| wdata | input | 8 | Register-bus write data |
| rdata | output | 8 | Register-bus read data, valid in the cycle of `rd_en` |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte can be taken this cycle |
| in_data | input | 8 | Stream message byte |

## Verification
The bench builds the block with its defaults: polynomial 0x1021, control at 0x84 and data port at 0x85. With these defaults the standard check string "123456789", preset to all ones, must end at 0x29B1. That gives an absolute reference for the CRC step in addition to the bench's own model. The default addresses sit next to each other, so decode slips are exposed by the random reads to 0x83 and 0x86. The byte-wide bus and the two-state pointer let random traffic reach every mix of pointer state, byte replacement, presetting and stream stalls within a few hundred operations.

// File: rtl/crc16_bp_pkg.sv
package crc16_bp_pkg;

  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NBYTES = CRC_W / BYTE_W;

  // control register bit positions
  localparam int CTL_INIT_BIT = 3;
  localparam int CTL_SEL_BIT  = 2;
  localparam int CTL_PTR_BIT  = 0;

  typedef struct packed {
    logic ctrl_wr;
    logic ctrl_rd;
    logic data_wr;
    logic data_rd;
  } bus_dec_t;

  // one byte of MSB-first CRC update
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0]  cur,
    input logic [BYTE_W-1:0] din,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = cur;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/crc16_bp_decode.sv
module crc16_bp_decode
  import crc16_bp_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h84,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h85
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output bus_dec_t          dec
);

  logic hit_ctrl;
  logic hit_data;

  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_data = (addr == DATA_ADDR);

  always_comb begin
    dec         = '0;
    dec.ctrl_wr = wr_en && hit_ctrl;
    dec.ctrl_rd = rd_en && hit_ctrl && !wr_en;
    dec.data_wr = wr_en && hit_data;
    dec.data_rd = rd_en && hit_data && !wr_en;
  end

endmodule

// File: rtl/crc16_bp_ctrl.sv
module crc16_bp_ctrl
  import crc16_bp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_dec_t dec,
  input  logic     wr_init,
  input  logic     wr_sel,
  input  logic     wr_ptr,
  output logic     init_pulse,
  output logic     preset_ones,
  output logic     sel_q,
  output logic     ptr_q
);

  logic data_access;

  assign data_access = dec.data_wr || dec.data_rd;
  assign init_pulse  = dec.ctrl_wr && wr_init;
  // preset follows the select bit written alongside the strobe
  assign preset_ones = wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      ptr_q <= 1'b0;
    end else if (dec.ctrl_wr) begin
      sel_q <= wr_sel;
      ptr_q <= wr_ptr;
    end else if (data_access) begin
      ptr_q <= ~ptr_q;
    end
  end

endmodule

// File: rtl/crc16_bp_engine.sv
module crc16_bp_engine
  import crc16_bp_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_pulse,
  input  logic              preset_ones,
  input  logic              byte_wr,
  input  logic              ptr,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              in_fire,
  input  logic [BYTE_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_q
);

  logic [NBYTES-1:0]      lane_hit;
  logic [CRC_W-1:0]       loaded;
  logic [CRC_W-1:0]       crc_d;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane_hit[b] = byte_wr && (int'(ptr) == b);
    assign loaded[b*BYTE_W +: BYTE_W] =
      lane_hit[b] ? wbyte : crc_q[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (init_pulse)      crc_d = preset_ones ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
    else if (byte_wr)    crc_d = loaded;
    else if (in_fire)    crc_d = crc_step(crc_q, in_data, POLY);
    else                 crc_d = crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else     crc_q <= crc_d;
  end

endmodule

// File: rtl/crc16_byteport.sv
module crc16_byteport
  import crc16_bp_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h84,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h85,
  parameter logic [15:0]       POLY      = 16'h1021
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data
);

  bus_dec_t         dec;
  logic             init_pulse;
  logic             preset_ones;
  logic             sel_q;
  logic             ptr_q;
  logic             in_fire;
  logic [CRC_W-1:0] crc_q;
  logic [7:0]       ctrl_view;
  logic [7:0]       data_view;

  crc16_bp_decode #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .wr_en(wr_en),
    .rd_en(rd_en),
    .addr (addr),
    .dec  (dec)
  );

  crc16_bp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .dec        (dec),
    .wr_init    (wdata[CTL_INIT_BIT]),
    .wr_sel     (wdata[CTL_SEL_BIT]),
    .wr_ptr     (wdata[CTL_PTR_BIT]),
    .init_pulse (init_pulse),
    .preset_ones(preset_ones),
    .sel_q      (sel_q),
    .ptr_q      (ptr_q)
  );

  // stall the stream while the bus claims the result register
  assign in_ready = !(init_pulse || dec.data_wr);
  assign in_fire  = in_valid && in_ready;

  crc16_bp_engine #(.POLY(POLY)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .init_pulse (init_pulse),
    .preset_ones(preset_ones),
    .byte_wr    (dec.data_wr),
    .ptr        (ptr_q),
    .wbyte      (wdata),
    .in_fire    (in_fire),
    .in_data    (in_data),
    .crc_q      (crc_q)
  );

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[CTL_SEL_BIT] = sel_q;
    ctrl_view[CTL_PTR_BIT] = ptr_q;
  end

  assign data_view = ptr_q ? crc_q[CRC_W-1:BYTE_W] : crc_q[BYTE_W-1:0];

  always_comb begin
    rdata = '0;
    if (dec.ctrl_rd)      rdata = ctrl_view;
    else if (dec.data_rd) rdata = data_view;
  end

endmodule

// File: rtl/crc16_byteport_chk.sv
module crc16_byteport_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h84,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h85
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       crc,
  input logic              ptr
);

  logic init_wr;
  logic data_acc;
  assign init_wr  = wr_en && addr == CTRL_ADDR && wdata[3];
  assign data_acc = addr == DATA_ADDR && (wr_en || rd_en);

  AST_INIT_PRESET: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> crc == ($past(wdata[2]) ? 16'hFFFF : 16'h0000)); // R2

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == CTRL_ADDR) |-> (rdata[7:3] == 5'd0 && rdata[1] == 1'b0)); // R4

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> ptr != $past(ptr)); // R6

  AST_STREAM_STALL: assert property (@(posedge clk) disable iff (rst)
    (init_wr || (wr_en && addr == DATA_ADDR)) |-> !in_ready); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !(in_valid && in_ready)) |=> $stable(crc)); // R10

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr != CTRL_ADDR && addr != DATA_ADDR) |-> rdata == 8'h00); // R11

endmodule

bind crc16_byteport crc16_byteport_chk #(
  .ADDR_W   (ADDR_W),
  .CTRL_ADDR(CTRL_ADDR),
  .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .crc     (crc_q),
  .ptr     (ptr_q)
);

// File: tb/crc16_byteport_test.sv
module crc16_byteport_test;

  localparam logic [7:0] A_CTRL = 8'h84;
  localparam logic [7:0] A_DATA = 8'h85;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, rd_en, in_valid;
  logic [7:0] addr, wdata, in_data;
  logic [7:0] rdata;
  logic       in_ready;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [15:0] m_crc;
  logic        m_ptr, m_sel;

  always #2 clk = ~clk;

  crc16_byteport #(
    .ADDR_W(8), .CTRL_ADDR(8'h84), .DATA_ADDR(8'h85), .POLY(16'h1021)
  ) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data)
  );

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++)
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    wr_en = 0; rd_en = 0; in_valid = 0; addr = 8'h00; wdata = 8'h00; in_data = 8'h00;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    idle_all(); wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1; idle_all();
    if (a == A_CTRL) begin
      if (d[3]) m_crc = d[2] ? 16'hFFFF : 16'h0000;
      m_sel = d[2]; m_ptr = d[0];
    end else if (a == A_DATA) begin
      if (m_ptr) m_crc[15:8] = d; else m_crc[7:0] = d;
      m_ptr = ~m_ptr;
    end
  endtask

  task automatic bus_rd_chk(input logic [7:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    idle_all(); rd_en = 1; addr = a;
    #1;
    if (a == A_CTRL)      exp = {5'b0, m_sel, 1'b0, m_ptr};
    else if (a == A_DATA) exp = m_ptr ? m_crc[15:8] : m_crc[7:0];
    else                  exp = 8'h00;
    chk(req, {8'h00, rdata}, {8'h00, exp});
    @(posedge clk); #1; idle_all();
    if (a == A_DATA) m_ptr = ~m_ptr;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    idle_all(); in_valid = 1; in_data = d;
    #1 chk("R9 ready when bus idle", {15'b0, in_ready}, 16'd1);
    @(posedge clk); #1; idle_all();
    m_crc = ref_crc(m_crc, d);
  endtask

  // reads both bytes through the pointer, starting from pointer 0
  task automatic read_result(input string req);
    bus_wr(A_CTRL, {5'b0, m_sel, 1'b0, 1'b0});
    bus_rd_chk(A_DATA, req);
    bus_rd_chk(A_DATA, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    string msg;
    idle_all();
    void'($urandom(32'd20240611));
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    m_crc = 0; m_ptr = 0; m_sel = 0;

    // R1 reset state
    bus_rd_chk(A_CTRL, "R1 reset control");
    bus_rd_chk(A_DATA, "R1 reset low byte");
    bus_rd_chk(A_DATA, "R1 reset high byte");

    // R2 presets
    bus_wr(A_CTRL, 8'h0C);
    read_result("R2 preset ones");
    bus_wr(A_CTRL, 8'h08);
    read_result("R2 preset zeros");

    // R3 and R4 readback with reserved bits set
    bus_wr(A_CTRL, 8'hF7);
    bus_rd_chk(A_CTRL, "R3 R4 control readback");
    bus_wr(A_CTRL, 8'hF2);
    bus_rd_chk(A_CTRL, "R4 reserved stay zero");

    // R5 R7 byte load through pointer
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_DATA, 8'h3C);
    bus_wr(A_DATA, 8'hA9);
    bus_rd_chk(A_DATA, "R5 R7 low byte");
    bus_rd_chk(A_DATA, "R5 R7 high byte");
    bus_wr(A_CTRL, 8'h01);
    bus_wr(A_DATA, 8'h55);
    bus_rd_chk(A_CTRL, "R6 pointer after write");
    read_result("R7 only high replaced");

    // R8 known check value
    bus_wr(A_CTRL, 8'h0C);
    for (int i = 0; i < 9; i++) push(8'h31 + 8'(i));
    chk("R8 check string", m_crc, 16'h29B1);
    read_result("R8 check value");

    // R9 init wins over stream byte
    @(negedge clk);
    idle_all(); wr_en = 1; addr = A_CTRL; wdata = 8'h0C; in_valid = 1; in_data = 8'hA5;
    #1 chk("R9 stall on init", {15'b0, in_ready}, 16'd0);
    @(posedge clk); #1;
    wr_en = 0; addr = 8'h00; wdata = 8'h00;
    #1 chk("R9 ready after init", {15'b0, in_ready}, 16'd1);
    @(posedge clk); #1; idle_all();
    m_crc = ref_crc(16'hFFFF, 8'hA5); m_sel = 1; m_ptr = 0;
    read_result("R9 byte taken after init");

    // R9 data write stalls stream
    @(negedge clk);
    idle_all(); wr_en = 1; addr = A_DATA; wdata = 8'h11; in_valid = 1; in_data = 8'h7E;
    #1 chk("R9 stall on data write", {15'b0, in_ready}, 16'd0);
    @(posedge clk); #1; idle_all();
    m_crc[7:0] = 8'h11; m_ptr = 1;
    read_result("R9 stalled byte not consumed");

    // R10 R11 holding and unused addresses
    repeat (5) @(posedge clk);
    bus_rd_chk(8'h83, "R11 other address");
    bus_rd_chk(8'h86, "R11 other address");
    bus_rd_chk(A_CTRL, "R6 R11 pointer unchanged");
    read_result("R10 result held");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 9);
      v  = 8'($urandom);
      case (op)
        0, 1, 2: push(v);
        3:       bus_wr(A_DATA, v);
        4:       bus_wr(A_CTRL, v);
        5, 6:    bus_rd_chk(A_DATA, "R5 R6 random data read");
        7:       bus_rd_chk(A_CTRL, "R3 random control read");
        8:       bus_rd_chk(v, "R11 random address read");
        default: begin
          repeat ($urandom_range(1, 3)) @(posedge clk);
          #1;
        end
      endcase
    end
    read_result("R8 R10 random final");

    msg = "";
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule